// File: doc/BRIEF.md
# I2C Byte Handshake and Clock Stretch Controller

This block paces an I2C transfer one byte at a time. It has a pending flag that is active low. While the flag is low, the block asks the pad logic to hold SCL low. This stretches the bus clock until software has dealt with the byte just moved. The flag drops after a completed byte, and each drop raises a one-cycle interrupt request. The flag is re-armed in two ways: software reads or writes the data buffer, or software writes a 1 into the flag through the control port. After the flag returns high, SCL stays held for one more programmable low period, and only then is it released.

In address-recognition mode, the first byte after a start condition is compared with a programmed 7-bit slave address and with the all-zero general-call pattern. A hit does three things: it drops the flag, it records the read/write bit, and it sets a sticky hit indication. That indication lasts until the next start. Later bytes of a transfer only stall the bus if the transfer was addressed to this node. In data-stream mode, every completed byte stalls the bus. A 2-bit mode field switches the whole handshake on or off. The bit shifter and the bus arbitration sit outside this block.

Top module: `i2c_byte_hold`

## Requirements
- R1: After reset, `pend` is 1, and `scl_hold`, `irq`, `addr_hit` and `dir_bit` are all 0.
- R2: While `mode_sel` is not 2'b10, the following hold from the next clock edge on, and all bus and CPU strobes are ignored:
  - `pend` is held at 1.
  - `scl_hold`, `irq`, `addr_hit` and `dir_bit` are 0.
- R3: Whenever `pend` is 0, `scl_hold` is 1.
- R4: With `addr_mode_en`=0, each `byte_done` pulse clears `pend` at the next clock edge.
- R5: With `addr_mode_en`=1, the first `byte_done` after `start_seen` is a match when `rx_byte[7:1]` equals `own_addr` or `rx_byte` is 8'h00. A match does the following:
  - `pend` is cleared.
  - `addr_hit` is set.
  - `dir_bit` takes `rx_byte[0]`.
  A byte that does not match leaves `pend` unchanged.
- R6: With `addr_mode_en`=1, a later `byte_done` clears `pend` only if a match has occurred since the last `start_seen`.
- R7: `start_seen` clears `addr_hit` and the selection at the next edge. A `byte_done` in the same cycle as `start_seen` is ignored.
- R8: A `buf_wr` or `buf_rd` pulse sets `pend` to 1. A `ctl_wr` with `ctl_pend_bit`=1 also sets it. A `ctl_wr` with `ctl_pend_bit`=0 has no effect.
- R9: When a clearing byte event and a setting CPU access fall in the same cycle, the clear wins.
- R10: `irq` is high for exactly one cycle, namely the first cycle in which `pend` reads 0 after having been 1, and at no other time.
- R11: When `pend` rises, `scl_hold` stays 1 for exactly `SCL_LOW_CYC` cycles and then goes to 0. If `pend` falls again during that window, the countdown is abandoned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Operating mode; 2'b10 enables the I2C handshake |
| addr_mode_en | input | 1 | 1 = address recognition, 0 = data-stream mode |
| own_addr | input | 7 | Programmed slave address |
| start_seen | input | 1 | One-cycle strobe: start condition detected |
| byte_done | input | 1 | One-cycle strobe: a byte completed on the bus |
| rx_byte | input | 8 | Byte just received, valid with `byte_done` |
| buf_wr | input | 1 | CPU write strobe to the data buffer |
| buf_rd | input | 1 | CPU read strobe from the data buffer |
| ctl_wr | input | 1 | CPU write strobe to the control register |
| ctl_pend_bit | input | 1 | Pending-flag bit of the control write data |
| pend | output | 1 | Pending flag, active low |
| scl_hold | output | 1 | 1 = pull SCL low |
| irq | output | 1 | One-cycle interrupt request |
| addr_hit | output | 1 | Sticky address or general-call hit since the last start |
| dir_bit | output | 1 | Read/write bit of the matching address byte |

## Verification
The bench drives several kinds of address byte and compares the results:
- an exact address match with the direction bit set;
- a general call;
- a byte that misses in its upper bits.
Comparing these separates the two match paths from a false match. Traffic after a miss is contrasted with traffic after a hit, which shows whether selection gates the later bytes. Data-stream mode shows that every byte stalls the bus regardless of selection. Several pairings are exercised:
- a clear and a set event in the same cycle;
- a start and a byte in the same cycle;
- a control write of 0 compared with a write of 1;
- a flag drop during the release countdown.
These pin down the priority rules. A long random stretch of mixed strobes, checked against a behavioural model on every clock, covers the interleavings the directed cases miss.

// File: rtl/ibh_pkg.sv
package ibh_pkg;
    localparam int unsigned ADDR_W = 7;
    localparam int unsigned BYTE_W = 8;
    localparam logic [1:0]  MODE_I2C = 2'b10;

    typedef struct packed {
        logic first_due;
        logic selected;
        logic hit;
        logic dir;
    } recog_state_t;

    function automatic logic is_i2c_mode(input logic [1:0] m);
        return m == MODE_I2C;
    endfunction

    function automatic logic addr_matches(input logic [BYTE_W-1:0] b,
                                          input logic [ADDR_W-1:0] own);
        return (b[BYTE_W-1:1] == own) || (b == '0);
    endfunction
endpackage

// File: rtl/ibh_addr_recog.sv
module ibh_addr_recog
    import ibh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              addr_mode_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              start_seen,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    output logic              pend_clr,
    output logic              addr_hit,
    output logic              dir_bit
);
    recog_state_t st, st_nxt;
    logic         match;

    assign match = addr_matches(rx_byte, own_addr);

    always_comb begin
        st_nxt   = st;
        pend_clr = 1'b0;
        if (!en) begin
            st_nxt = '0;
        end else if (start_seen) begin
            st_nxt.first_due = 1'b1;
            st_nxt.selected  = 1'b0;
            st_nxt.hit       = 1'b0;
        end else if (byte_done) begin
            if (!addr_mode_en) begin
                st_nxt.first_due = 1'b0;
                pend_clr         = 1'b1;
            end else if (st.first_due) begin
                st_nxt.first_due = 1'b0;
                if (match) begin
                    st_nxt.selected = 1'b1;
                    st_nxt.hit      = 1'b1;
                    st_nxt.dir      = rx_byte[0];
                    pend_clr        = 1'b1;
                end
            end else if (st.selected) begin
                pend_clr = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st <= '0;
        else     st <= st_nxt;
    end

    assign addr_hit = st.hit;
    assign dir_bit  = st.dir;
endmodule

// File: rtl/ibh_pend_flag.sv
module ibh_pend_flag (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic clr,
    input  logic set,
    output logic pend,
    output logic pend_nxt,
    output logic rise,
    output logic irq
);
    always_comb begin
        if (!en)      pend_nxt = 1'b1;
        else if (clr) pend_nxt = 1'b0;
        else if (set) pend_nxt = 1'b1;
        else          pend_nxt = pend;
    end

    assign rise = en & ~pend & pend_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b1;
            irq  <= 1'b0;
        end else begin
            pend <= pend_nxt;
            irq  <= en & pend & ~pend_nxt;
        end
    end
endmodule

// File: rtl/ibh_release_timer.sv
module ibh_release_timer #(
    parameter int unsigned LOW_CYC = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic abort,
    output logic busy
);
    localparam int unsigned CW = (LOW_CYC < 1) ? 1 : $clog2(LOW_CYC + 1);

    generate
        if (LOW_CYC == 0) begin : g_none
            assign busy = 1'b0;
        end else begin : g_cnt
            logic [CW-1:0] cnt;
            always_ff @(posedge clk) begin
                if (rst || abort)   cnt <= '0;
                else if (load)      cnt <= CW'(LOW_CYC);
                else if (cnt != '0) cnt <= cnt - 1'b1;
            end
            assign busy = (cnt != '0);
        end
    endgenerate
endmodule

// File: rtl/i2c_byte_hold.sv
module i2c_byte_hold
    import ibh_pkg::*;
#(
    parameter int unsigned SCL_LOW_CYC = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode_sel,
    input  logic              addr_mode_en,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              start_seen,
    input  logic              byte_done,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              buf_wr,
    input  logic              buf_rd,
    input  logic              ctl_wr,
    input  logic              ctl_pend_bit,
    output logic              pend,
    output logic              scl_hold,
    output logic              irq,
    output logic              addr_hit,
    output logic              dir_bit
);
    logic en, pend_clr, pend_set, pend_nxt, pend_rise, busy;

    assign en       = is_i2c_mode(mode_sel);
    assign pend_set = buf_wr | buf_rd | (ctl_wr & ctl_pend_bit);

    ibh_addr_recog u_recog (
        .clk(clk), .rst(rst), .en(en), .addr_mode_en(addr_mode_en),
        .own_addr(own_addr), .start_seen(start_seen), .byte_done(byte_done),
        .rx_byte(rx_byte), .pend_clr(pend_clr), .addr_hit(addr_hit),
        .dir_bit(dir_bit)
    );

    ibh_pend_flag u_flag (
        .clk(clk), .rst(rst), .en(en), .clr(pend_clr), .set(pend_set),
        .pend(pend), .pend_nxt(pend_nxt), .rise(pend_rise), .irq(irq)
    );

    ibh_release_timer #(.LOW_CYC(SCL_LOW_CYC)) u_timer (
        .clk(clk), .rst(rst), .load(pend_rise),
        .abort(~en | ~pend_nxt), .busy(busy)
    );

    assign scl_hold = ~pend | busy;
endmodule

// File: rtl/ibh_checker.sv
module ibh_checker #(
    parameter int unsigned LOW_CYC = 8
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] mode_sel,
    input logic       start_seen,
    input logic       byte_done,
    input logic       buf_wr,
    input logic       buf_rd,
    input logic       pend,
    input logic       scl_hold,
    input logic       irq,
    input logic       addr_hit
);
    localparam int unsigned CW = $clog2(LOW_CYC + 2);

    logic          pend_q, en_q, rose;
    logic [CW-1:0] win;

    assign rose = pend & ~pend_q & en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b1;
            en_q   <= 1'b0;
        end else begin
            pend_q <= pend;
            en_q   <= (mode_sel == 2'b10);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !pend || !(mode_sel == 2'b10)) win <= '0;
        else if (rose)                            win <= CW'(LOW_CYC) - 1'b1;
        else if (win != '0)                       win <= win - 1'b1;
    end

    a_r3_hold_while_low: assert property (@(posedge clk) disable iff (rst)
        !pend |-> scl_hold);

    a_r10_irq_on_fall: assert property (@(posedge clk) disable iff (rst)
        $fell(pend) |-> irq);

    a_r10_irq_only_on_fall: assert property (@(posedge clk) disable iff (rst)
        irq |-> (!pend && $past(pend)));

    a_r2_idle_when_off: assert property (@(posedge clk) disable iff (rst)
        (mode_sel != 2'b10) |=> (pend && !scl_hold && !irq && !addr_hit));

    a_r7_start_clears_hit: assert property (@(posedge clk) disable iff (rst)
        start_seen |=> !addr_hit);

    a_r8_access_sets: assert property (@(posedge clk) disable iff (rst)
        ((mode_sel == 2'b10) && (buf_wr || buf_rd) && !byte_done) |=> pend);

    a_r11_hold_in_window: assert property (@(posedge clk) disable iff (rst)
        (LOW_CYC > 0 && en_q && pend && (rose || win != '0)) |-> scl_hold);

    a_r11_release_after: assert property (@(posedge clk) disable iff (rst)
        (en_q && pend && !rose && win == '0) |-> !scl_hold);
endmodule

bind i2c_byte_hold ibh_checker #(.LOW_CYC(SCL_LOW_CYC)) u_chk (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .start_seen(start_seen),
    .byte_done(byte_done), .buf_wr(buf_wr), .buf_rd(buf_rd), .pend(pend),
    .scl_hold(scl_hold), .irq(irq), .addr_hit(addr_hit)
);

// File: tb/i2c_byte_hold_tb_top.sv
module i2c_byte_hold_tb_top;
    localparam int N = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode_sel = 2'b00;
    logic       addr_mode_en = 1'b1;
    logic [6:0] own_addr = 7'h2A;
    logic       start_seen = 1'b0, byte_done = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       buf_wr = 1'b0, buf_rd = 1'b0, ctl_wr = 1'b0, ctl_pend_bit = 1'b0;
    logic       pend, scl_hold, irq, addr_hit, dir_bit;

    int    checks = 0, failures = 0;
    bit    finished = 1'b0;
    string cur_req = "R1";

    // behavioural reference state
    int m_pend = 1, m_cnt = 0, m_irq = 0, m_hit = 0, m_dir = 0, m_first = 0, m_sel = 0;

    always #4 clk = ~clk;

    i2c_byte_hold #(.SCL_LOW_CYC(N)) dut_i (
        .clk(clk), .rst(rst), .mode_sel(mode_sel), .addr_mode_en(addr_mode_en),
        .own_addr(own_addr), .start_seen(start_seen), .byte_done(byte_done),
        .rx_byte(rx_byte), .buf_wr(buf_wr), .buf_rd(buf_rd), .ctl_wr(ctl_wr),
        .ctl_pend_bit(ctl_pend_bit), .pend(pend), .scl_hold(scl_hold),
        .irq(irq), .addr_hit(addr_hit), .dir_bit(dir_bit)
    );

    always @(posedge clk) begin
        int clr, nxt;
        if (rst) begin
            m_pend = 1; m_cnt = 0; m_irq = 0; m_hit = 0; m_dir = 0; m_first = 0; m_sel = 0;
        end else if (mode_sel != 2'b10) begin
            m_pend = 1; m_cnt = 0; m_irq = 0; m_hit = 0; m_dir = 0; m_first = 0; m_sel = 0;
        end else begin
            clr = 0;
            if (start_seen) begin
                m_first = 1; m_sel = 0; m_hit = 0;
            end else if (byte_done) begin
                if (!addr_mode_en) begin
                    clr = 1; m_first = 0;
                end else if (m_first != 0) begin
                    m_first = 0;
                    if (rx_byte == 8'h00 || (rx_byte >> 1) == own_addr) begin
                        m_sel = 1; m_hit = 1; m_dir = rx_byte[0]; clr = 1;
                    end
                end else if (m_sel != 0) clr = 1;
            end
            if (clr != 0) nxt = 0;
            else if (buf_wr || buf_rd || (ctl_wr && ctl_pend_bit)) nxt = 1;
            else nxt = m_pend;
            m_irq = (m_pend == 1 && nxt == 0) ? 1 : 0;
            if (nxt == 1 && m_pend == 0) m_cnt = N;
            else if (nxt == 0) m_cnt = 0;
            else if (m_cnt > 0) m_cnt = m_cnt - 1;
            m_pend = nxt;
        end
    end

    task automatic chk(string sig, int act, int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", cur_req, sig, act, exp);
        end
    endtask

    task automatic cyc();
        int exp_hold;
        @(posedge clk);
        @(negedge clk);
        exp_hold = (m_pend == 0 || m_cnt > 0) ? 1 : 0;
        chk("pend", pend, m_pend);
        chk("scl_hold", scl_hold, exp_hold);
        chk("irq", irq, m_irq);
        chk("addr_hit", addr_hit, m_hit);
        chk("dir_bit", dir_bit, m_dir);
        start_seen = 0; byte_done = 0; buf_wr = 0; buf_rd = 0; ctl_wr = 0; ctl_pend_bit = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic start_then(logic [7:0] b);
        start_seen = 1; cyc();
        rx_byte = b; byte_done = 1; cyc();
    endtask

    task finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        cur_req = "R1"; idle(2);
        chk("R1 pend", pend, 1); chk("R1 scl_hold", scl_hold, 0);

        cur_req = "R2"; // disabled mode ignores everything
        start_then(8'h54); byte_done = 1; cyc(); ctl_wr = 1; cyc(); idle(2);
        mode_sel = 2'b11; start_then(8'h00); idle(2);

        mode_sel = 2'b10; addr_mode_en = 1; own_addr = 7'h2A;
        cur_req = "R5"; // exact match, direction 1
        start_then(8'h55);
        chk("R5 dir_bit", dir_bit, 1); chk("R10 irq", irq, 1);
        cur_req = "R3"; idle(4);
        chk("R3 scl_hold", scl_hold, 1);
        cur_req = "R11"; buf_rd = 1; cyc(); idle(N + 2);
        chk("R11 released", scl_hold, 0);

        cur_req = "R6"; rx_byte = 8'h33; byte_done = 1; cyc(); idle(2);
        cur_req = "R8"; ctl_wr = 1; ctl_pend_bit = 0; cyc(); idle(2);
        chk("R8 write0 no effect", pend, 0);
        ctl_wr = 1; ctl_pend_bit = 1; cyc(); idle(N + 1);
        buf_wr = 1; cyc(); idle(2);

        cur_req = "R5"; // general call
        start_then(8'h00); chk("R5 gc hit", addr_hit, 1); buf_wr = 1; cyc(); idle(N);

        cur_req = "R6"; // mismatch: later bytes must not stall
        start_then(8'h44); chk("R6 miss pend", pend, 1);
        rx_byte = 8'h00; byte_done = 1; cyc(); idle(2);
        chk("R6 unselected byte", pend, 1);

        cur_req = "R7"; // start with byte in same cycle
        start_seen = 1; byte_done = 1; rx_byte = 8'h54; cyc(); idle(2);
        rx_byte = 8'h54; byte_done = 1; cyc(); chk("R7 hit after", addr_hit, 1);
        start_seen = 1; cyc(); chk("R7 start clears hit", addr_hit, 0);
        buf_wr = 1; cyc(); idle(N);

        cur_req = "R4"; addr_mode_en = 0;
        rx_byte = 8'hA5; byte_done = 1; cyc(); chk("R4 clear", pend, 0);
        buf_rd = 1; cyc(); idle(2);
        cur_req = "R11"; // clear during countdown
        rx_byte = 8'h01; byte_done = 1; cyc(); idle(N + 3);
        cur_req = "R9"; byte_done = 1; buf_wr = 1; cyc();
        chk("R9 clear wins", pend, 0);
        cur_req = "R2"; mode_sel = 2'b01; cyc(); idle(2);
        chk("R2 off", scl_hold, 0);

        cur_req = "R10 random"; mode_sel = 2'b10;
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = $urandom % 100;
            start_seen   = (r < 6);
            byte_done    = ($urandom % 5) == 0;
            rx_byte      = (($urandom % 3) == 0) ? 8'h54 | 8'($urandom % 2) : 8'($urandom);
            buf_wr       = ($urandom % 9) == 0;
            buf_rd       = ($urandom % 11) == 0;
            ctl_wr       = ($urandom % 13) == 0;
            ctl_pend_bit = $urandom % 2;
            if (($urandom % 200) == 0) addr_mode_en = ~addr_mode_en;
            if (($urandom % 300) == 0) mode_sel = 2'($urandom);
            if (($urandom % 40) == 0) mode_sel = 2'b10;
            cyc();
        end
        finish_up();
    end
endmodule